// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block derives the SCL waveform for an I2C master engine from the system clock. Software loads a 12-bit divider value N through two byte-wide registers and picks one of two timing modes. In standard mode each SCL period takes 2·(N−1)+7 system clocks. In fast mode it takes 3·(N−1)+9 system clocks. Standard periods are split almost evenly between the low and high phases. Fast periods give the low phase about twice the length of the high phase.

The block runs freely from reset. A period always starts with its low phase. The divider and mode are sampled only when a new period starts, so a register write that arrives mid-period never stretches or cuts the SCL phase in progress. One-cycle strobes mark the start of each low phase and each high phase, and the protocol engine uses them to move SDA and to sample it. The block also holds a 3-bit field that gives the input clock frequency band. Other logic uses that field to size its filter and setup delays.

Top module: `sclk_div`

## Requirements
- R1: The divider N is assembled as {ext[4:0], ctl[6:0]}, where ctl is the byte written with `ctl_we` and ext is the byte written with `ext_we`. Bits 7:5 of an ext write have no effect on the SCL timing.
- R2: Bit 7 of a ctl write selects the mode: 1 selects fast and 0 selects standard.
- R3: In standard mode the low phase lasts N+3 clocks and the high phase lasts N+2 clocks, giving a period of 2·(N−1)+7.
- R4: In fast mode the low phase lasts 2N+4 clocks and the high phase lasts N+2 clocks, giving a period of 3·(N−1)+9.
- R5: A divider value of 0 or 1 produces exactly the timing of N=2 in the selected mode.
- R6: A write with `rng_we` stores `wr_data[7:5]` in the frequency band field, which is driven on `rng_o`. The other bits of that write are ignored. The field resets to code 2 (register byte 0x40).
- R7: `low_stb_o` is high for exactly one clock, in the first clock in which `scl_o` is 0. `high_stb_o` is high for exactly one clock, in the first clock in which `scl_o` is 1.
- R8: A divider or mode write takes effect only when the next period starts. The low and high phases already under way keep the lengths they started with.
- R9: During and after reset, `scl_o` is 0 and both strobes are 0. The first period uses N=2 in standard mode, so `scl_o` rises after the 5th clock edge following reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Write strobe for the control byte (mode bit and divider bits 6:0) |
| ext_we | input | 1 | Write strobe for the extension byte (divider bits 11:7) |
| rng_we | input | 1 | Write strobe for the frequency band byte |
| wr_data | input | 8 | Byte written by any of the three strobes |
| scl_o | output | 1 | SCL level request, 0 in the low phase |
| low_stb_o | output | 1 | One-clock pulse at the start of each low phase (period start) |
| high_stb_o | output | 1 | One-clock pulse at the start of each high phase |
| rng_o | output | 3 | Stored input frequency band code |

## Verification
A corrupted phase counter or latched divider appears at the ports within one SCL period, as a low or high phase whose length differs from the one computed from N and the mode. A divider latched at the wrong moment changes the phase lengths of the period during which a write lands. The bench measures those lengths exactly, in clock cycles, between consecutive strobes. A strobe that fires in the wrong cycle, or stays high for longer than one cycle, becomes visible as soon as `scl_o` changes level.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    // smallest legal divider; smaller programmed values behave like this one
    localparam int MIN_DIV = 2;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FAST = 1'b1
    } sclk_mode_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } sclk_phase_e;

endpackage

// File: rtl/sclk_cfg_regs.sv
module sclk_cfg_regs
    import sclk_pkg::*;
#(
    parameter int REG_W   = 8,
    parameter int DIV_W   = 12,
    parameter int LO_W    = 7,
    parameter int RNG_W   = 3,
    parameter int RNG_RST = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ext_we,
    input  logic             rng_we,
    input  logic [REG_W-1:0] wr_data,
    output logic [DIV_W-1:0] div_raw,
    output sclk_mode_e       mode,
    output logic [RNG_W-1:0] rng
);

    localparam int HI_W    = DIV_W - LO_W;
    localparam int RNG_LSB = REG_W - RNG_W;
    localparam int MODE_B  = REG_W - 1;

    typedef struct packed {
        logic [LO_W-1:0]  div_lo;
        logic [HI_W-1:0]  div_hi;
        sclk_mode_e       mode;
        logic [RNG_W-1:0] rng;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (ctl_we) begin
            cfg_d.div_lo = wr_data[LO_W-1:0];
            cfg_d.mode   = sclk_mode_e'(wr_data[MODE_B]);
        end
        if (ext_we) begin
            cfg_d.div_hi = wr_data[HI_W-1:0];
        end
        if (rng_we) begin
            cfg_d.rng = wr_data[REG_W-1:RNG_LSB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.div_lo <= '0;
            cfg_q.div_hi <= '0;
            cfg_q.mode   <= MODE_STD;
            cfg_q.rng    <= RNG_W'(RNG_RST);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign div_raw = {cfg_q.div_hi, cfg_q.div_lo};
    assign mode    = cfg_q.mode;
    assign rng     = cfg_q.rng;

    // R6: the band field follows the top bits of the written byte
    a_r6_rng_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rng_we |=> rng == $past(wr_data[REG_W-1:RNG_LSB]));

    // R1: the extension write lands in the upper divider bits only
    a_r1_ext_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_we && !ctl_we) |=> (div_raw[DIV_W-1:LO_W] == $past(wr_data[HI_W-1:0]))
                                && $stable(div_raw[LO_W-1:0]));

endmodule

// File: rtl/sclk_phase_len.sv
module sclk_phase_len
    import sclk_pkg::*;
#(
    parameter int DIV_W = 12,
    parameter int CNT_W = 14
) (
    input  logic [DIV_W-1:0] div_in,
    input  sclk_mode_e       mode_in,
    output logic [DIV_W-1:0] div_eff,
    output logic [CNT_W-1:0] low_reload,
    output logic [CNT_W-1:0] high_reload
);

    logic [CNT_W-1:0] n_ext;

    always_comb begin
        // values below the legal minimum run as the minimum
        div_eff = (div_in < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_in;
        n_ext   = CNT_W'(div_eff);
        // reload values are phase length minus one
        // standard: low N+3, high N+2    fast: low 2N+4, high N+2
        if (mode_in == MODE_FAST) begin
            low_reload = (n_ext << 1) + CNT_W'(3);
        end else begin
            low_reload = n_ext + CNT_W'(2);
        end
        high_reload = n_ext + CNT_W'(1);
    end

endmodule

// File: rtl/sclk_phase_gen.sv
module sclk_phase_gen
    import sclk_pkg::*;
#(
    parameter int DIV_W = 12,
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_new,
    input  sclk_mode_e       mode_new,
    input  logic [CNT_W-1:0] low_reload_new,
    input  logic [CNT_W-1:0] high_reload_cur,
    output logic [DIV_W-1:0] div_cur,
    output sclk_mode_e       mode_cur,
    output logic             scl,
    output logic             low_stb,
    output logic             high_stb
);

    // reset period: N = MIN_DIV in standard mode, low length MIN_DIV+3
    localparam int CNT_RST = MIN_DIV + 2;

    typedef struct packed {
        sclk_phase_e      phase;
        logic [CNT_W-1:0] cnt;
        logic [DIV_W-1:0] div;
        sclk_mode_e       mode;
        logic             lstb;
        logic             hstb;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d      = gen_q;
        gen_d.lstb = 1'b0;
        gen_d.hstb = 1'b0;
        if (gen_q.cnt == '0) begin
            if (gen_q.phase == PH_LOW) begin
                gen_d.phase = PH_HIGH;
                gen_d.cnt   = high_reload_cur;
                gen_d.hstb  = 1'b1;
            end else begin
                // period boundary: the only point that samples the setup
                gen_d.phase = PH_LOW;
                gen_d.cnt   = low_reload_new;
                gen_d.div   = div_new;
                gen_d.mode  = mode_new;
                gen_d.lstb  = 1'b1;
            end
        end else begin
            gen_d.cnt = gen_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q.phase <= PH_LOW;
            gen_q.cnt   <= CNT_W'(CNT_RST);
            gen_q.div   <= DIV_W'(MIN_DIV);
            gen_q.mode  <= MODE_STD;
            gen_q.lstb  <= 1'b0;
            gen_q.hstb  <= 1'b0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign div_cur  = gen_q.div;
    assign mode_cur = gen_q.mode;
    assign scl      = (gen_q.phase == PH_HIGH);
    assign low_stb  = gen_q.lstb;
    assign high_stb = gen_q.hstb;

    // R5: the divider in use never falls below the legal minimum
    a_r5_min_div: assert property (@(posedge clk) disable iff (!rst_n)
        gen_q.div >= DIV_W'(MIN_DIV));

    // R8: the setup in use changes only when a period starts
    a_r8_hold_setup: assert property (@(posedge clk) disable iff (!rst_n)
        !low_stb |-> ($stable(gen_q.div) && $stable(gen_q.mode)));

    // R7: strobes are single-cycle pulses
    a_r7_low_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        low_stb |=> !low_stb);
    a_r7_high_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        high_stb |=> !high_stb);

    // R7: every level change of SCL comes with its strobe
    a_r7_rise_marked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl) |-> high_stb);
    a_r7_fall_marked: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl) |-> low_stb);

    // R3: a standard low phase never runs longer than N+3
    a_r3_std_low_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl && gen_q.mode == MODE_STD) |-> gen_q.cnt <= CNT_W'(gen_q.div) + CNT_W'(2));

    // R4: a high phase in either mode never runs longer than N+2
    a_r4_high_bound: assert property (@(posedge clk) disable iff (!rst_n)
        scl |-> gen_q.cnt <= CNT_W'(gen_q.div) + CNT_W'(1));

endmodule

// File: rtl/sclk_div.sv
module sclk_div
    import sclk_pkg::*;
#(
    parameter int REG_W   = 8,
    parameter int DIV_W   = 12,
    parameter int LO_W    = 7,
    parameter int RNG_W   = 3,
    parameter int RNG_RST = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ext_we,
    input  logic             rng_we,
    input  logic [REG_W-1:0] wr_data,
    output logic             scl_o,
    output logic             low_stb_o,
    output logic             high_stb_o,
    output logic [RNG_W-1:0] rng_o
);

    // fast low phase reaches 2N+4, which needs two bits above the divider
    localparam int CNT_W = DIV_W + 2;

    logic [DIV_W-1:0] div_raw;
    sclk_mode_e       mode_raw;
    logic [DIV_W-1:0] div_new;
    logic [CNT_W-1:0] low_reload_new;
    logic [CNT_W-1:0] high_reload_unused;
    logic [DIV_W-1:0] div_cur;
    sclk_mode_e       mode_cur;
    logic [DIV_W-1:0] div_cur_eff;
    logic [CNT_W-1:0] low_reload_unused;
    logic [CNT_W-1:0] high_reload_cur;

    sclk_cfg_regs #(
        .REG_W  (REG_W),
        .DIV_W  (DIV_W),
        .LO_W   (LO_W),
        .RNG_W  (RNG_W),
        .RNG_RST(RNG_RST)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_we (ctl_we),
        .ext_we (ext_we),
        .rng_we (rng_we),
        .wr_data(wr_data),
        .div_raw(div_raw),
        .mode   (mode_raw),
        .rng    (rng_o)
    );

    // lengths for the period about to start, from the live registers
    sclk_phase_len #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_len_next (
        .div_in     (div_raw),
        .mode_in    (mode_raw),
        .div_eff    (div_new),
        .low_reload (low_reload_new),
        .high_reload(high_reload_unused)
    );

    // lengths for the period under way, from the latched setup
    sclk_phase_len #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_len_cur (
        .div_in     (div_cur),
        .mode_in    (mode_cur),
        .div_eff    (div_cur_eff),
        .low_reload (low_reload_unused),
        .high_reload(high_reload_cur)
    );

    sclk_phase_gen #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_gen (
        .clk            (clk),
        .rst_n          (rst_n),
        .div_new        (div_new),
        .mode_new       (mode_raw),
        .low_reload_new (low_reload_new),
        .high_reload_cur(high_reload_cur),
        .div_cur        (div_cur),
        .mode_cur       (mode_cur),
        .scl            (scl_o),
        .low_stb        (low_stb_o),
        .high_stb       (high_stb_o)
    );

    // R5: the latched divider is already legal, so clamping it is a no-op
    a_r5_cur_legal: assert property (@(posedge clk) disable iff (!rst_n)
        div_cur_eff == div_cur);

endmodule

// File: tb/sclk_div_test.sv
`timescale 1ns/1ps
module sclk_div_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic       ext_we = 1'b0;
    logic       rng_we = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       scl_o;
    logic       low_stb_o;
    logic       high_stb_o;
    logic [2:0] rng_o;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sclk_div uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ext_we    (ext_we),
        .rng_we    (rng_we),
        .wr_data   (wr_data),
        .scl_o     (scl_o),
        .low_stb_o (low_stb_o),
        .high_stb_o(high_stb_o),
        .rng_o     (rng_o)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    // callers stand at a negedge; writes land on the following posedge
    task automatic wr(input int which, input logic [7:0] d);
        wr_data = d;
        ctl_we  = (which == 0);
        ext_we  = (which == 1);
        rng_we  = (which == 2);
        @(negedge clk);
        ctl_we = 1'b0;
        ext_we = 1'b0;
        rng_we = 1'b0;
    endtask

    task automatic set_cfg(input bit fast, input int n);
        logic [11:0] nv;
        nv = 12'(n);
        wr(0, {fast, nv[6:0]});
        wr(1, {3'b101, nv[11:7]});   // junk in bits 7:5 (R1)
    endtask

    function automatic int exp_lo(input bit fast, input int n);
        int ne;
        ne = (n < 2) ? 2 : n;
        return fast ? 2 * ne + 4 : ne + 3;
    endfunction

    function automatic int exp_hi(input int n);
        int ne;
        ne = (n < 2) ? 2 : n;
        return ne + 2;
    endfunction

    // measure from a low strobe seen t0 cycles ago up to the next low strobe
    task automatic meas_rest(input int t0, output int lo, output int hi, output bit bad);
        int t;
        t   = t0;
        lo  = -1;
        hi  = -1;
        bad = 1'b0;
        while (1) begin
            @(negedge clk);
            t++;
            if (t > 40000) begin
                bad = 1'b1;
                break;
            end
            if (low_stb_o) begin
                if (scl_o || lo < 0) bad = 1'b1;
                else hi = t - lo;
                break;
            end
            if (high_stb_o) begin
                if (lo >= 0 || !scl_o) bad = 1'b1;
                lo = t;
            end else if (lo < 0 && scl_o) begin
                bad = 1'b1;
            end else if (lo >= 0 && !scl_o) begin
                bad = 1'b1;
            end
        end
    endtask

    task automatic sync_low();
        int g;
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!low_stb_o && g < 40000);
    endtask

    task automatic meas(output int lo, output int hi, output bit bad);
        sync_low();
        meas_rest(0, lo, hi, bad);
    endtask

    task automatic run_point(input bit fast, input int n);
        int lo, hi;
        bit bad;
        string req;
        set_cfg(fast, n);
        meas(lo, hi, bad);
        req = fast ? "R4" : "R3";
        if (n < 2) req = {req, "/R5"};
        check(req, $sformatf("low len fast=%0d n=%0d", fast, n), lo, exp_lo(fast, n));
        check(req, $sformatf("high len fast=%0d n=%0d", fast, n), hi, exp_hi(n));
        check("R7", $sformatf("strobe/level shape n=%0d", n), int'(bad), 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        int lo, hi, t;
        bit bad;
        repeat (3) @(negedge clk);
        // R9: reset values
        check("R9", "scl in reset", int'(scl_o), 0);
        check("R9", "low strobe in reset", int'(low_stb_o), 0);
        check("R6", "band reset code", int'(rng_o), 2);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R9", "scl after 4 edges", int'(scl_o), 0);
        check("R9", "high strobe after 4 edges", int'(high_stb_o), 0);
        @(negedge clk);
        check("R9", "scl after 5 edges", int'(scl_o), 1);
        check("R9", "high strobe after 5 edges", int'(high_stb_o), 1);

        // R2, R3, R4, R5: sweep of small dividers in both modes
        for (int m = 0; m < 2; m++) begin
            for (int n = 0; n <= 40; n++) begin
                run_point(m[0], n);
            end
        end
        // R1: values that need the extension byte
        run_point(1'b0, 127);
        run_point(1'b0, 128);
        run_point(1'b1, 1000);
        run_point(1'b0, 4095);
        run_point(1'b1, 4095);
        run_point(1'b1, 128);

        // R8: write during a low phase keeps the running period
        set_cfg(1'b0, 10);
        sync_low();
        wr(0, {1'b1, 7'd3});
        meas_rest(1, lo, hi, bad);
        check("R8", "low len after mid-low write", lo, 13);
        check("R8", "high len after mid-low write", hi, 12);
        meas(lo, hi, bad);
        check("R8", "next period low len", lo, 10);
        check("R8", "next period high len", hi, 5);

        // R8: write during a high phase keeps the running high phase
        t = 0;
        do begin
            @(negedge clk);
        end while (!high_stb_o);
        wr(0, {1'b0, 7'd20});
        t = 1;
        while (!low_stb_o && t < 40000) begin
            @(negedge clk);
            t++;
        end
        check("R8", "high len after mid-high write", t, 5);
        meas_rest(0, lo, hi, bad);
        check("R8", "new std low len", lo, 23);
        check("R8", "new std high len", hi, 22);

        // R6: band field takes only the top three bits
        wr(2, 8'hFF);
        check("R6", "band after 0xFF", int'(rng_o), 7);
        wr(2, 8'h1F);
        check("R6", "band after 0x1F", int'(rng_o), 0);
        wr(2, 8'hA5);
        check("R6", "band after 0xA5", int'(rng_o), 5);
        meas(lo, hi, bad);
        check("R6", "band write leaves low len", lo, 23);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule